// File: doc/BRIEF.md
# Burst-of-two quad-rate SRAM model

This block is a cycle-accurate, synthesizable model of a static memory with separate read and write ports. Every transaction moves two words, and each word takes half of the slow memory clock. The model runs on one fast clock at twice the memory clock rate. An internal phase flag alternates between the rising edge of the memory clock (the K phase) and the rising edge of its complement (the K# phase). Addresses and port selects are taken only on K-phase ticks. The second write word and its lane mask are taken on the K#-phase tick that follows.

Read data returns three fast ticks after the address is captured, which is one and a half memory clock cycles. Both words of a read come back on consecutive ticks, with a flag that stands in for the output drivers being enabled. The read and write ports are independent, and both may start in the same K cycle.

Data moves at fixed times. The block has no valid/ready handshake and cannot stall. A caller must present the second write word on the tick after the first word and must accept read data on the ticks where `rd_oe` is high.

Top module: `qdr_b2_sram`

## Requirements
- R1: After reset, `half_sel` is 0 in the cycle before the first rising clock edge. It then alternates on every clock edge. A tick whose edge is preceded by `half_sel`=0 is a K-phase tick. A tick preceded by 1 is a K#-phase tick.
- R2: On a K-phase tick with `wr_sel_n` low, `wr_addr` is captured and `wr_data` is stored at internal word {wr_addr,0}. On the K#-phase tick that follows, `wr_data` is stored at {wr_addr,1}.
- R3: On a K-phase tick n with `rd_sel_n` low, `rd_addr` is captured. Word {rd_addr,0} is driven on `rd_data` with `rd_oe` high after edge n+3, and word {rd_addr,1} after edge n+4. Back-to-back reads give a continuous stream.
- R4: Within one transaction, the burst order is always word A+0 and then word A+1, where A+1 is the captured address with the burst bit set to 1.
- R5: `wr_lane_n` bit i covers bits [9i+8:9i] and is sampled separately for each half of a write. A low bit writes that lane. A high bit leaves that lane of the word unchanged.
- R6: When no read data is due, `rd_oe` is low and `rd_data` is all zeros, which stands for high impedance. A K cycle with both selects high changes no stored word.
- R7: While `rst_n` is low, and in the cycle after reset is released, `rd_oe` is low and `rd_data` is zero.
- R8: A read and a write to different addresses in the same K cycle both complete as if each were alone.
- R9: A read started in the same K cycle as a write to the same address returns the merged words after both write halves, including partially written lanes.
- R10: `rd_sel_n`, `wr_sel_n` and both address buses are ignored on K#-phase ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the memory clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read start, sampled on the K phase |
| wr_sel_n | input | 1 | Active-low write start, sampled on the K phase |
| rd_addr | input | ADDR_W | Read burst address |
| wr_addr | input | ADDR_W | Write burst address |
| wr_lane_n | input | LANES | Active-low per-lane write enables, one per 9-bit lane |
| wr_data | input | 9*LANES | Write word for the current half |
| half_sel | output | 1 | 0 when the next edge is a K-phase tick |
| rd_data | output | 9*LANES | Read word, zero when not driven |
| rd_oe | output | 1 | Output enable, low models high impedance |

## Verification
The bench aims at a read and a write to the same address in one K cycle, with different lane masks in each half. A model that reads the array too early would return stale data in the second word. A model that reads too late would pick up the next cycle's write. Selects and addresses are toggled on K#-phase ticks: a design that samples them there would start a phantom burst or corrupt a stored word. Partial and empty masks expose lanes that are written regardless of their select. Long random mixes of back-to-back reads check that a burst arriving one tick early or late, or with its words swapped, is caught.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;
  localparam int LANE_W = 9;
  localparam logic PH_K  = 1'b0;
  localparam logic PH_KB = 1'b1;
endpackage

// File: rtl/qdr_b2_phase.sv
module qdr_b2_phase
  import qdr_b2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_K;
    else        phase <= ~phase;
  end

  assert_phase_k_to_kb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_K) |=> (phase == PH_KB));
  assert_phase_kb_to_k_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_KB) |=> (phase == PH_K));
endmodule

// File: rtl/qdr_b2_wr_port.sv
module qdr_b2_wr_port
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lane_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              we,
  output logic [ADDR_W:0]   waddr,
  output logic [LANES-1:0]  wmask,
  output logic [DATA_W-1:0] wdat
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else if (phase == PH_K) begin
      pend_q <= ~wr_sel_n;
      addr_q <= wr_addr;
    end else begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (phase == PH_K) begin
      we    = ~wr_sel_n;
      waddr = {wr_addr, 1'b0};
    end else begin
      we    = pend_q;
      waddr = {addr_q, 1'b1};
    end
    wmask = ~wr_lane_n;
    wdat  = wr_data;
  end

  // second half of a write only follows a first half
  assert_second_half_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && phase == PH_KB) |-> $past(we));
endmodule

// File: rtl/qdr_b2_array.sv
module qdr_b2_array
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int DEPTH  = 2 ** (ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W:0]   waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [DATA_W-1:0] wdat,
  input  logic [ADDR_W:0]   raddr,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdat[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/qdr_b2_rd_pipe.sv
module qdr_b2_rd_pipe
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   raddr,
  input  logic [DATA_W-1:0] rword,
  output logic [DATA_W-1:0] q,
  output logic              q_en
);
  logic              pend_q, v1, v2;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] st1, st2;

  // word 0 is fetched on the K# tick, word 1 on the next K tick,
  // so both halves of a same-cycle write are already stored
  assign raddr = {addr_q, (phase == PH_K)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
      st1    <= '0;
      st2    <= '0;
      q      <= '0;
      q_en   <= 1'b0;
    end else begin
      if (phase == PH_K) begin
        pend_q <= ~rd_sel_n;
        addr_q <= rd_addr;
      end
      v1   <= pend_q;
      st1  <= pend_q ? rword : '0;
      v2   <= v1;
      st2  <= st1;
      q_en <= v2;
      q    <= v2 ? st2 : '0;
    end
  end

  assert_idle_after_reset_R7: assert property (@(posedge clk)
    !rst_n |=> (!q_en && q == '0));
  assert_burst_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_en) |=> q_en);
  assert_first_word_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_en) |-> (phase == PH_K));
  assert_zero_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> (q == '0));
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lane_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              half_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  logic              phase, we;
  logic [ADDR_W:0]   waddr, raddr;
  logic [LANES-1:0]  wmask;
  logic [DATA_W-1:0] wdat, rword;

  qdr_b2_phase u_phase (.clk(clk), .rst_n(rst_n), .phase(phase));

  qdr_b2_wr_port #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wr_sel_n(wr_sel_n),
    .wr_addr(wr_addr), .wr_lane_n(wr_lane_n), .wr_data(wr_data),
    .we(we), .waddr(waddr), .wmask(wmask), .wdat(wdat));

  qdr_b2_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wmask(wmask), .wdat(wdat),
    .raddr(raddr), .rword(rword));

  qdr_b2_rd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_rd (
    .clk(clk), .rst_n(rst_n), .phase(phase), .rd_sel_n(rd_sel_n),
    .rd_addr(rd_addr), .raddr(raddr), .rword(rword), .q(rd_data), .q_en(rd_oe));

  assign half_sel = phase;
endmodule

// File: tb/test_qdr_b2_sram.sv
`timescale 1ns/1ps
module test_qdr_b2_sram;
  localparam int AW = 4;
  localparam int LN = 2;
  localparam int DW = 9 * LN;
  localparam int NT = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [LN-1:0] wr_lane_n = '1;
  logic [DW-1:0] wr_data = '0;
  logic half_sel, rd_oe;
  logic [DW-1:0] rd_data;

  qdr_b2_sram #(.ADDR_W(AW), .LANES(LN)) i_qdr_b2_sram (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_lane_n(wr_lane_n), .wr_data(wr_data),
    .half_sel(half_sel), .rd_data(rd_data), .rd_oe(rd_oe));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [DW-1:0] model [2**(AW+1)];
  logic          exp_oe [NT];
  logic [DW-1:0] exp_q  [NT];
  string         exp_tag [NT];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LN-1:0] lane_n);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LN; i++) if (!lane_n[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s tick %0d: actual %h expected %h", tag, cyc, act, expv);
    end
  endtask

  // sampling 1 ns after each edge
  always begin
    @(posedge clk); #1;
    if (!done) begin
      if (!rst_n) begin
        check("R7", {31'd0, rd_oe}, 32'd0);
        check("R7", 32'(rd_data), 32'd0);
      end else if (cyc < NT) begin
        check("R1", {31'd0, half_sel}, {31'd0, cyc[0]});
        check(exp_tag[cyc], {31'd0, rd_oe}, {31'd0, exp_oe[cyc]});
        check(exp_tag[cyc], 32'(rd_data), 32'(exp_q[cyc]));
      end
    end
  end

  // one K cycle; called at a negedge with cyc even
  task automatic kcyc(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                      logic [DW-1:0] d0, logic [LN-1:0] m0,
                      logic [DW-1:0] d1, logic [LN-1:0] m1, bit stray, string tag);
    int e = cyc + 1;
    rd_sel_n = ~rd; wr_sel_n = ~wr; rd_addr = ra; wr_addr = wa;
    wr_data = d0; wr_lane_n = m0;
    if (wr) begin
      model[{wa,1'b0}] = merge(model[{wa,1'b0}], d0, m0);
      model[{wa,1'b1}] = merge(model[{wa,1'b1}], d1, m1);
    end
    if (rd && e + 4 < NT) begin
      exp_oe[e+3] = 1'b1; exp_q[e+3] = model[{ra,1'b0}]; exp_tag[e+3] = tag;
      exp_oe[e+4] = 1'b1; exp_q[e+4] = model[{ra,1'b1}]; exp_tag[e+4] = tag;
    end
    @(negedge clk);
    wr_data = d1; wr_lane_n = m1;
    if (stray) begin  // R10: selects and addresses on the K# tick
      rd_sel_n = 1'b0; wr_sel_n = 1'b0;
      rd_addr = AW'($urandom); wr_addr = AW'($urandom);
    end else begin
      rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NT; i++) begin exp_oe[i] = 0; exp_q[i] = '0; exp_tag[i] = "R6"; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;   // cyc is 0 here; the next edge is a K tick
    // R2: fill every word with full masks
    for (int a = 0; a < 2**AW; a++)
      kcyc(0, '0, 1, AW'(a), DW'(a*37+5), '0, DW'(a*91+1000), '0, 0, "R2");
    for (int a = 0; a < 2**AW; a += 5) kcyc(1, AW'(a), 0, '0, '0, '1, '0, '1, 0, "R2");
    // R4: distinct halves, read back order
    kcyc(0, '0, 1, 4'd3, 18'h0aaaa, '0, 18'h15555, '0, 0, "R4");
    kcyc(1, 4'd3, 0, '0, '0, '1, '0, '1, 0, "R4");
    // R5: lane masks per half, and an empty mask
    kcyc(0, '0, 1, 4'd5, 18'h3ffff, 2'b10, 18'h3ffff, 2'b01, 0, "R5");
    kcyc(0, '0, 1, 4'd6, 18'h12345, 2'b11, 18'h01234, 2'b11, 0, "R5");
    kcyc(1, 4'd5, 0, '0, '0, '1, '0, '1, 0, "R5");
    kcyc(1, 4'd6, 0, '0, '0, '1, '0, '1, 0, "R5");
    // R6: idle cycles with write data toggling
    kcyc(0, '0, 0, 4'd7, 18'h3ffff, '0, 18'h3ffff, '0, 0, "R6");
    kcyc(0, '0, 0, 4'd7, 18'h00001, '0, 18'h00002, '0, 0, "R6");
    kcyc(1, 4'd7, 0, '0, '0, '1, '0, '1, 0, "R6");
    // R8: read and write to different addresses
    kcyc(1, 4'd9, 1, 4'd10, 18'h0beef, '0, 18'h0cafe, '0, 0, "R8");
    kcyc(1, 4'd10, 0, '0, '0, '1, '0, '1, 0, "R8");
    // R9: same address, partial masks
    kcyc(1, 4'd11, 1, 4'd11, 18'h2f0f0, 2'b01, 18'h10f0f, 2'b10, 0, "R9");
    kcyc(1, 4'd11, 1, 4'd11, 18'h11111, '0, 18'h22222, '0, 0, "R9");
    kcyc(1, 4'd11, 0, '0, '0, '1, '0, '1, 0, "R9");
    // R10: stray selects on K# ticks
    kcyc(0, '0, 0, '0, '0, '1, '0, '1, 1, "R10");
    kcyc(0, '0, 0, '0, '0, '1, '0, '1, 1, "R10");
    for (int a = 0; a < 2**AW; a++) kcyc(1, AW'(a), 0, '0, '0, '1, '0, '1, 0, "R10");
    // R3: random mix, many back-to-back reads
    for (int k = 0; k < 600; k++)
      kcyc(($urandom % 4) != 0, AW'($urandom), ($urandom % 2) == 1, AW'($urandom),
           DW'($urandom), LN'($urandom), DW'($urandom), LN'($urandom),
           ($urandom % 8) == 0, "R3");
    repeat (8) @(negedge clk);
    finish_run();
  end
endmodule